// File: doc/BRIEF.md
# E1 Gapped-Clock Transmit Serial Master

This block drives the system side of one E1 transmit link as the timing master. It divides a core clock down to a bit clock, emits a one-bit-wide frame pulse, samples a serial payload line and a parallel signaling line on clock edges it chooses, and hands each captured 8-bit timeslot to the core as a one-cycle strobe. The strobe carries the slot number, its signaling nibble and frame and multiframe start flags.

In full operation all 32 slots of every frame receive clock edges. In fractional operation a 32-bit mask picks slots whose clock is suppressed, either for the whole slot or, with the bit-8-only option, for the last bit of each masked slot only. Data presented during a suppressed interval never reaches the output. The frame pulse launch edge and the data sampling edge are set separately. A three-bit type field picks whether the pulse marks every frame, multiframe starts, or both. A polarity input inverts the pulse pin.

Top module: `e1tx_master`

## Requirements
- R1: The bit clock `sck` has a period of 2*HALF_CYC core cycles: low for the first half of each bit period and high for the second half. A frame is 32 slots of 8 bits, and with an all-zero mask no bit period is suppressed.
- R2: With `bit8_only`=0, a set bit k of `gap_mask` holds `sck` low for all 8 bit periods of slot k, and slot k produces no strobe.
- R3: With `bit8_only`=1, `sck` is held low only in the eighth bit period of each masked slot. The slot still produces a strobe, with `slot_data[0]` forced to 0.
- R4: `sd` is sampled on the rising edge in the middle of a bit period when `data_edge_fall`=0, and on the falling edge that opens the bit period when it is 1. The first bit of a slot lands in `slot_data[7]` (MSB first).
- R5: The frame pulse is one bit period wide and changes on falling edges when `fp_edge_rise`=0, on rising edges when it is 1. If both settings select the same edge, the pulse ends on the edge that samples bit 1 of slot 0. If they differ, it ends half a bit period earlier.
- R6: `fp_type` bit 0 marks every frame. Bit 1 (CRC multiframe) and bit 2 (signaling multiframe) each mark frames whose count is 0 modulo 16. With all bits clear, no pulse is produced.
- R7: `fp_active_low`=1 makes `fp` idle high and pulse low. With 0 it idles low and pulses high.
- R8: `sig` is captured on the sampling edge of bit 1 of a slot and is reported in `slot_sig` with that slot's strobe.
- R9: `slot_valid` is high for exactly one core cycle, starting on the sampling edge of bit 8 of each non-suppressed slot (or where that edge would fall when bit 8 is gapped). It carries `slot_num`, `slot_fs` (slot 0) and `slot_mfs` (slot 0 of a frame whose count is 0).
- R10: While reset is held, `sck` is low, `fp` is at its idle level and `slot_valid` is low. Counting starts on the third rising clock edge after `rst_n` is released, and the first bit period after reset is bit 1 of slot 0 of frame count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_mask | input | 32 | Slot gapping mask, bit k for slot k |
| bit8_only | input | 1 | Gap only bit 8 of masked slots |
| fp_edge_rise | input | 1 | Frame pulse changes on rising (1) or falling (0) edges |
| data_edge_fall | input | 1 | Data sampled on falling (1) or rising (0) edges |
| fp_type | input | 3 | Pulse marks: bit0 frame, bit1 CRC multiframe, bit2 signaling multiframe |
| fp_active_low | input | 1 | Invert frame pulse pin |
| sck | output | 1 | Bit clock toward the system |
| fp | output | 1 | Frame pulse toward the system |
| sd | input | 1 | Serial payload from the system |
| sig | input | 4 | Signaling bits, aligned per slot |
| slot_valid | output | 1 | One-cycle strobe per captured slot |
| slot_data | output | 8 | Captured slot, first bit in MSB |
| slot_sig | output | 4 | Signaling captured with the slot |
| slot_num | output | 5 | Slot index |
| slot_fs | output | 1 | Slot is slot 0 |
| slot_mfs | output | 1 | Slot 0 of a multiframe start frame |

## Verification
The block is run in full mode with per-frame pulses, and with a whole-slot mask that includes slots 0 and 31, so that the absence of strobes and clock pulses at the frame edges is separated from ordinary slot handling. A bit-8-only mask then tells the forced zero bit apart from data that is actually sampled. The four combinations of launch and sampling edges, together with every pulse type and both polarities, show whether the pulse lands in the right half period and in the right frame across a 16-frame wrap. Payload and signaling are random on every cycle, so data from a gap or from the wrong edge cannot match by chance.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;
  parameter int SLOTS  = 32;
  parameter int BITS   = 8;
  parameter int MF_LEN = 16;
  parameter int SIG_W  = 4;

  localparam int TS_W  = $clog2(SLOTS);
  localparam int B_W   = $clog2(BITS);
  localparam int FR_W  = $clog2(MF_LEN);
  localparam int IDX_W = TS_W + B_W + 1;

  // position of the bit clock within the multiframe, half-period resolution
  typedef struct packed {
    logic [FR_W-1:0] fr;
    logic [TS_W-1:0] ts;
    logic [B_W-1:0]  b;
    logic            h;  // 0: low half, 1: high half
  } pos_t;

  typedef struct packed {
    logic sig_mf;
    logic crc_mf;
    logic basic;
  } fpsel_t;
endpackage

// File: rtl/e1tx_timebase.sv
module e1tx_timebase
  import e1tx_pkg::*;
#(
  parameter int HALF_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output pos_t pos_nxt
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] HC_LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] hcnt_q, hcnt_d;
  pos_t          pos_q, pos_d;

  always_comb begin
    tick    = (hcnt_q == HC_LAST);
    hcnt_d  = tick ? '0 : hcnt_q + 1'b1;
    pos_nxt = pos_q;
    if (!pos_q.h) begin
      pos_nxt.h = 1'b1;
    end else begin
      pos_nxt.h = 1'b0;
      if (pos_q.b == B_W'(BITS - 1)) begin
        pos_nxt.b = '0;
        if (pos_q.ts == TS_W'(SLOTS - 1)) begin
          pos_nxt.ts = '0;
          pos_nxt.fr = (pos_q.fr == FR_W'(MF_LEN - 1)) ? '0 : pos_q.fr + 1'b1;
        end else begin
          pos_nxt.ts = pos_q.ts + 1'b1;
        end
      end else begin
        pos_nxt.b = pos_q.b + 1'b1;
      end
    end
    pos_d = tick ? pos_nxt : pos_q;
  end

  // reset parks on the last half of the multiframe so the first step enters slot 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q   <= '0;
      pos_q.fr <= FR_W'(MF_LEN - 1);
      pos_q.ts <= TS_W'(SLOTS - 1);
      pos_q.b  <= B_W'(BITS - 1);
      pos_q.h  <= 1'b1;
    end else begin
      hcnt_q <= hcnt_d;
      pos_q  <= pos_d;
    end
  end
endmodule

// File: rtl/e1tx_decode.sv
module e1tx_decode
  import e1tx_pkg::*;
(
  input  pos_t             p,
  input  logic [SLOTS-1:0] gap_mask,
  input  logic             bit8_only,
  input  logic             de_fall,
  input  logic             fp_rise,
  input  logic [2:0]       fp_type,
  output logic             sck_d,
  output logic             fp_d,
  output logic             samp,
  output logic             strobe,
  output logic             bit_gap
);
  fpsel_t           sel;
  logic             slot_m, bit_last, slot_gap, at_samp, lead, mark;
  logic [IDX_W-1:0] idx, s_idx, end_idx, e1, e2;
  logic [FR_W-1:0]  nf;

  always_comb begin
    sel      = fpsel_t'(fp_type);
    slot_m   = gap_mask[p.ts];
    bit_last = (p.b == B_W'(BITS - 1));
    slot_gap = slot_m & ~bit8_only;
    bit_gap  = slot_m & (~bit8_only | bit_last);

    sck_d    = p.h & ~bit_gap;
    at_samp  = (p.h == ~de_fall);
    samp     = at_samp & ~bit_gap;
    strobe   = at_samp & bit_last & ~slot_gap;

    // the pulse ends on the sampling half of bit 1, or one half earlier if edges differ
    idx      = {p.ts, p.b, p.h};
    s_idx    = {{(IDX_W-1){1'b0}}, ~de_fall};
    lead     = ~(fp_rise ^ de_fall);
    end_idx  = s_idx - {{(IDX_W-1){1'b0}}, lead};
    e1       = end_idx - IDX_W'(1);
    e2       = end_idx - IDX_W'(2);
    if (idx[IDX_W-1])
      nf = (p.fr == FR_W'(MF_LEN - 1)) ? '0 : p.fr + 1'b1;
    else
      nf = p.fr;
    mark     = sel.basic | ((sel.crc_mf | sel.sig_mf) & (nf == '0));
    fp_d     = mark & ((idx == e1) | (idx == e2));
  end
endmodule

// File: rtl/e1tx_capture.sv
module e1tx_capture
  import e1tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             samp,
  input  logic             strobe,
  input  logic             bit_gap,
  input  logic             first_bit,
  input  logic [TS_W-1:0]  ts,
  input  logic             fr_zero,
  input  logic             sd,
  input  logic [SIG_W-1:0] sig,
  output logic             valid,
  output logic [BITS-1:0]  data,
  output logic [SIG_W-1:0] sig_o,
  output logic [TS_W-1:0]  ts_o,
  output logic             fs_o,
  output logic             mfs_o
);
  logic [BITS-2:0]  sh_q, sh_d;
  logic [SIG_W-1:0] sigc_q, sigc_d, sig_o_d;
  logic             valid_d, fs_d, mfs_d;
  logic [BITS-1:0]  data_d;
  logic [TS_W-1:0]  ts_d;

  always_comb begin
    sh_d    = sh_q;
    sigc_d  = sigc_q;
    valid_d = 1'b0;
    data_d  = data;
    sig_o_d = sig_o;
    ts_d    = ts_o;
    fs_d    = fs_o;
    mfs_d   = mfs_o;
    if (tick && samp) begin
      sh_d = {sh_q[BITS-3:0], sd};
      if (first_bit) sigc_d = sig;
    end
    if (tick && strobe) begin
      valid_d = 1'b1;
      data_d  = {sh_q, bit_gap ? 1'b0 : sd};
      sig_o_d = sigc_q;
      ts_d    = ts;
      fs_d    = (ts == '0);
      mfs_d   = (ts == '0) & fr_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      sigc_q <= '0;
      valid  <= 1'b0;
      data   <= '0;
      sig_o  <= '0;
      ts_o   <= '0;
      fs_o   <= 1'b0;
      mfs_o  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      sigc_q <= sigc_d;
      valid  <= valid_d;
      data   <= data_d;
      sig_o  <= sig_o_d;
      ts_o   <= ts_d;
      fs_o   <= fs_d;
      mfs_o  <= mfs_d;
    end
  end
endmodule

// File: rtl/e1tx_master.sv
module e1tx_master
  import e1tx_pkg::*;
#(
  parameter int HALF_CYC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] gap_mask,
  input  logic             bit8_only,
  input  logic             fp_edge_rise,
  input  logic             data_edge_fall,
  input  logic [2:0]       fp_type,
  input  logic             fp_active_low,
  output logic             sck,
  output logic             fp,
  input  logic             sd,
  input  logic [SIG_W-1:0] sig,
  output logic             slot_valid,
  output logic [BITS-1:0]  slot_data,
  output logic [SIG_W-1:0] slot_sig,
  output logic [TS_W-1:0]  slot_num,
  output logic             slot_fs,
  output logic             slot_mfs
);
  logic [1:0] rsync_q;
  logic       srst_n;
  logic       tick, sck_d, fp_d, samp, strobe, bit_gap;
  logic       sck_q, fp_q, sck_n, fp_n;
  pos_t       pos_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  e1tx_timebase #(.HALF_CYC(HALF_CYC)) tb_i (
    .clk(clk), .rst_n(srst_n), .tick(tick), .pos_nxt(pos_nxt)
  );

  e1tx_decode dec_i (
    .p(pos_nxt), .gap_mask(gap_mask), .bit8_only(bit8_only),
    .de_fall(data_edge_fall), .fp_rise(fp_edge_rise), .fp_type(fp_type),
    .sck_d(sck_d), .fp_d(fp_d), .samp(samp), .strobe(strobe), .bit_gap(bit_gap)
  );

  e1tx_capture cap_i (
    .clk(clk), .rst_n(srst_n), .tick(tick), .samp(samp), .strobe(strobe),
    .bit_gap(bit_gap), .first_bit(pos_nxt.b == '0), .ts(pos_nxt.ts),
    .fr_zero(pos_nxt.fr == '0), .sd(sd), .sig(sig),
    .valid(slot_valid), .data(slot_data), .sig_o(slot_sig), .ts_o(slot_num),
    .fs_o(slot_fs), .mfs_o(slot_mfs)
  );

  always_comb begin
    sck_n = tick ? sck_d : sck_q;
    fp_n  = tick ? fp_d  : fp_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sck_q <= 1'b0;
      fp_q  <= 1'b0;
    end else begin
      sck_q <= sck_n;
      fp_q  <= fp_n;
    end
  end

  assign sck = sck_q;
  assign fp  = fp_q ^ fp_active_low;
endmodule

// File: rtl/e1tx_master_chk.sv
module e1tx_master_chk #(
  parameter int HALF_CYC = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        sck,
  input logic        fp_act,
  input logic [2:0]  fp_type,
  input logic [31:0] gap_mask,
  input logic        bit8_only,
  input logic        slot_valid,
  input logic [4:0]  slot_num
);
  logic [31:0] run_len;
  logic        prev_fp, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      prev_fp <= 1'b0;
      armed   <= 1'b0;
    end else begin
      run_len <= fp_act ? run_len + 1 : '0;
      prev_fp <= fp_act;
      if (prev_fp && !fp_act) armed <= 1'b1;
    end
  end

  // R1: the bit clock only moves on a half-period step
  p_sck_on_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck));

  // R2: a whole-slot gap never yields a strobe
  p_gapped_slot_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !bit8_only) |-> !gap_mask[slot_num]);

  // R5: every complete pulse after the first is one bit period long
  p_fp_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_fp && !fp_act) |-> (run_len == 32'(2 * HALF_CYC)));

  // R6: no pulse when no mark type is chosen
  p_no_pulse_unselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_type == 3'b000) |-> !fp_act);

  // R9: strobe lasts one cycle
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |=> !slot_valid);
endmodule

bind e1tx_master e1tx_master_chk #(.HALF_CYC(HALF_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sck(sck), .fp_act(fp_q),
  .fp_type(fp_type), .gap_mask(gap_mask), .bit8_only(bit8_only),
  .slot_valid(slot_valid), .slot_num(slot_num)
);

// File: tb/e1tx_master_tb_top.sv
module e1tx_master_tb_top;
  localparam int HC = 2;

  logic        clk, rst_n;
  logic [31:0] cfg_mask;
  logic        cfg_b8, cfg_fpr, cfg_def, cfg_inv;
  logic [2:0]  cfg_typ;
  logic        sd;
  logic [3:0]  sig;
  logic        sck, fp, valid, fs, mfs;
  logic [7:0]  data;
  logic [3:0]  sig_o;
  logic [4:0]  ts_o;

  e1tx_master #(.HALF_CYC(HC)) dut_i (
    .clk(clk), .rst_n(rst_n), .gap_mask(cfg_mask), .bit8_only(cfg_b8),
    .fp_edge_rise(cfg_fpr), .data_edge_fall(cfg_def), .fp_type(cfg_typ),
    .fp_active_low(cfg_inv), .sck(sck), .fp(fp), .sd(sd), .sig(sig),
    .slot_valid(valid), .slot_data(data), .slot_sig(sig_o), .slot_num(ts_o),
    .slot_fs(fs), .slot_mfs(mfs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_strb = 0, n_bad = 0;
  bit live = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  // behavioural reference: global half-period count since reset
  int         skip, cc, g;
  bit         m_sck, m_fp, m_valid, m_fs, m_mfs;
  logic [7:0] m_data;
  logic [3:0] m_sig, sig_cap;
  logic [4:0] m_ts;
  bit         bq[$];

  task automatic model_step();
    int h, bt, ts, fr, sh, f2, off, lead, e;
    bit slot_m, gapb, whole, mark;
    h      = g % 2;
    bt     = (g / 2) % 8;
    ts     = (g / 16) % 32;
    fr     = (g / 512) % 16;
    slot_m = cfg_mask[ts];
    gapb   = slot_m && (!cfg_b8 || bt == 7);
    whole  = slot_m && !cfg_b8;
    sh     = cfg_def ? 0 : 1;
    m_sck  = (h == 1) && !gapb;
    if (h == sh) begin
      if (!gapb) begin
        if (bt == 0) begin bq.delete(); sig_cap = sig; end
        bq.push_back(sd);
      end
      if (bt == 7 && !whole) begin
        if (gapb) bq.push_back(1'b0);
        m_data = '0;
        for (int i = 0; i < 8; i++) m_data = {m_data[6:0], (i < bq.size()) ? bq[i] : 1'b0};
        m_valid = 1;
        m_ts    = 5'(ts);
        m_sig   = sig_cap;
        m_fs    = (ts == 0);
        m_mfs   = (ts == 0) && (fr == 0);
      end
    end
    f2   = (g + 3) / 512;
    off  = g - f2 * 512;
    lead = (cfg_fpr != !cfg_def) ? 1 : 0;
    e    = sh - lead;
    mark = cfg_typ[0] || ((cfg_typ[2:1] != 2'b00) && (f2 % 16 == 0));
    m_fp = mark && (off == e - 1 || off == e - 2);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      skip = 2; cc = 0; g = -1;
      m_sck = 0; m_fp = 0; m_valid = 0;
      bq.delete();
    end else if (skip > 0) begin
      skip--;
    end else begin
      m_valid = 0;
      if (cc == HC - 1) begin
        cc = 0;
        g++;
        model_step();
      end else begin
        cc++;
      end
    end
  end

  always @(negedge clk) begin
    sd  <= 1'($urandom_range(0, 1));
    sig <= 4'($urandom_range(0, 15));
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      check("R1 R2 R3 sck", {31'd0, sck}, {31'd0, m_sck});
      check("R5 R6 R7 fp", {31'd0, fp}, {31'd0, m_fp ^ cfg_inv});
      check("R9 R2 valid", {31'd0, valid}, {31'd0, m_valid});
      if (valid && m_valid) begin
        check("R4 R3 data", {24'd0, data}, {24'd0, m_data});
        check("R9 slot number", {27'd0, ts_o}, {27'd0, m_ts});
        check("R8 signaling", {28'd0, sig_o}, {28'd0, m_sig});
        check("R9 frame flags", {30'd0, fs, mfs}, {30'd0, m_fs, m_mfs});
      end
      if (valid) n_strb++;
      if (valid && !cfg_b8 && cfg_mask[ts_o]) n_bad++;
    end
  end

  task automatic run_cfg(input logic [31:0] mask, input logic b8, input logic fpr,
                         input logic def, input logic [2:0] typ, input logic inv,
                         input int nfr);
    int kept;
    @(negedge clk);
    live = 0; rst_n = 1'b0;
    cfg_mask = mask; cfg_b8 = b8; cfg_fpr = fpr; cfg_def = def;
    cfg_typ = typ; cfg_inv = inv;
    repeat (3) @(negedge clk);
    check("R10 reset sck", {31'd0, sck}, 32'd0);
    check("R10 R7 reset fp idle", {31'd0, fp}, {31'd0, inv});
    check("R10 reset valid", {31'd0, valid}, 32'd0);
    n_strb = 0; n_bad = 0;
    rst_n = 1'b1; live = 1;
    repeat ((nfr * 512 + 4) * HC + 2) @(negedge clk);
    kept = 32 - (b8 ? 0 : $countones(mask));
    check("R2 R3 strobe count", n_strb, nfr * kept);
    check("R2 strobes in gapped slots", n_bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; sd = 1'b0; sig = '0;
    cfg_mask = '0; cfg_b8 = 0; cfg_fpr = 0; cfg_def = 0; cfg_typ = 3'b001; cfg_inv = 0;
    run_cfg(32'h0000_0000, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 2);   // full, frame marks
    run_cfg(32'h8000_0013, 1'b0, 1'b0, 1'b1, 3'b010, 1'b1, 17);  // slot gaps, CRC MF, inverted
    run_cfg(32'h00F0_F00F, 1'b1, 1'b1, 1'b0, 3'b100, 1'b0, 17);  // bit-8 gaps, signaling MF
    run_cfg(32'h0000_0400, 1'b0, 1'b1, 1'b1, 3'b011, 1'b0, 3);   // rising launch, falling sample
    run_cfg(32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 2);   // only slot 0 kept, no pulses
    live = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule